// File: doc/BRIEF.md
# Two-Level Thermal Migration Coordinator

This block is the central decision maker of a multi-core thermal manager. Once per management interval it takes a snapshot of every core's predicted temperature, predicted deviation from the chip average, occupancy and running task ID. It then issues task start and stop commands that keep cores below a hard temperature limit and, when there is room, even out the temperature across the chip. The per-core predictors that produce these numbers sit outside the block.

Threshold avoidance always comes first. Every occupied core whose temperature prediction has reached the proactive level is told to stop its task, and that task joins a pending queue. Pending tasks are then handed, oldest first, to free cores that are cool enough. The balance stage runs only in an interval that produced no threshold command and that ends with an empty queue. That stage moves one task from the occupied core with the largest positive deviation to the free core with the smallest deviation, provided the deviation reaches a trigger level. The trigger level is scaled by the ratio of cores to running tasks.

Commands leave the block one per cycle as a stream. Each command carries its core index and task ID. A stop always travels with a minimum-frequency request and a start always travels with a maximum-frequency request.

Top module: `thermal_migr_coord`

## Requirements
- R1: After reset no command is issued and the pending queue is empty, so an interval with all cores free and cool produces no command.
- R2: On an interval tick, every occupied core whose temperature prediction is at least PRO_LVL (default 39) is sent a stop command, in ascending core order. A core at PRO_LVL-1 is left running.
- R3: Stopped tasks enter a first-in-first-out queue. In the same interval, queued tasks are started oldest first on free cores whose prediction is at most AVAIL_LVL (default 33), scanning cores in ascending order. A free core at AVAIL_LVL+1 receives no task.
- R4: Tasks that cannot be placed stay queued across intervals and are placed in a later interval once a qualifying free core exists.
- R5: If any stop or start was issued by the threshold stage in an interval, or the queue is not empty after the assignment scan, no balance move happens in that interval.
- R6: The balance trigger is floor(BAL_LVL*N_CORES/M), where M is the number of occupied cores at the tick (defaults: 24/M). If the largest deviation among occupied cores is at least that trigger, the block stops the task on that core and then starts the same task on the free core with the smallest deviation. Ties go to the lowest core index.
- R7: No balance move happens when the largest deviation is below the trigger, when no core is free, or when M is zero.
- R8: When the queue already holds N_CORES tasks, a core that meets the stop condition is left running and no command is issued for it.
- R9: Command encoding: cmd_start=1 means start and cmd_start=0 means stop. cmd_fmax=1 requests maximum frequency and is issued with every start. cmd_fmax=0 requests minimum frequency and is issued with every stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Management interval start; taken only while idle |
| core_busy | input | N_CORES | Bit i set when core i runs a task |
| core_task | input | N_CORES*TASK_W | Task ID per core, core i at bits i*TASK_W |
| thr_pred | input | N_CORES*PRED_W | Unsigned temperature prediction per core |
| bal_dev | input | N_CORES*DEV_W | Signed deviation prediction per core |
| cmd_valid | output | 1 | A command is present this cycle |
| cmd_start | output | 1 | 1 = start task, 0 = stop task |
| cmd_fmax | output | 1 | 1 = maximum frequency, 0 = minimum frequency |
| cmd_core | output | IDX_W | Target core index |
| cmd_task | output | TASK_W | Task ID carried by the command |

## Verification
The hardest state to reach from the ports is a completely full pending queue followed by a fresh hot core. That state needs every core to be evicted in one interval while no core is cool enough to take a task back. The stimulus drives all eight cores hot in one interval, keeps every prediction above the availability level in the next, and then places new tasks on three cores with hot predictions. It then cools the chip and checks that the queue drains oldest first. Balance moves are exercised at several occupancy counts so that the divided trigger is checked at its floor boundaries.

// File: rtl/thermco_pkg.sv
package thermco_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_THRESH_SCAN,
        ST_ASSIGN,
        ST_BAL_WAIT,
        ST_BAL_ACT,
        ST_ISSUE
    } coord_state_e;

    typedef struct packed {
        logic start;
        logic fmax;
    } cmd_op_t;

    localparam cmd_op_t OP_STOP  = '{start: 1'b0, fmax: 1'b0};
    localparam cmd_op_t OP_START = '{start: 1'b1, fmax: 1'b1};

endpackage

// File: rtl/thermco_taskq.sv
module thermco_taskq #(
    parameter int DEPTH = 8,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    // R8: a push never lands on a full queue
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R3: only a queued task can be handed out
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/thermco_div.sv
module thermco_div #(
    parameter int DIVD_W = 5,
    parameter int DIVS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIVD_W-1:0] dividend,
    input  logic [DIVS_W-1:0] divisor,
    output logic              done,
    output logic [DIVD_W-1:0] quo
);
    localparam int STEP_W = $clog2(DIVD_W + 1);

    logic [DIVS_W:0]   rem;
    logic [DIVS_W:0]   shifted;
    logic [STEP_W-1:0] steps;
    logic              busy;

    assign shifted = {rem[DIVS_W-1:0], quo[DIVD_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            quo   <= '0;
            steps <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                quo   <= dividend;
                steps <= STEP_W'(DIVD_W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (shifted >= {1'b0, divisor}) begin
                    rem <= shifted - {1'b0, divisor};
                    quo <= {quo[DIVD_W-2:0], 1'b1};
                end else begin
                    rem <= shifted;
                    quo <= {quo[DIVD_W-2:0], 1'b0};
                end
                steps <= steps - 1'b1;
                if (steps == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R7: the divider is never started with zero running tasks
    assert_div_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> (divisor != '0));

endmodule

// File: rtl/thermco_pick.sv
module thermco_pick #(
    parameter int N_CORES = 8,
    parameter int DEV_W   = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_CORES*DEV_W-1:0] dev_flat,
    input  logic [N_CORES-1:0]       occ,
    output logic [IDX_W-1:0]         hot_idx,
    output logic                     hot_ok,
    output logic [IDX_W-1:0]         cool_idx,
    output logic                     cool_ok
);
    logic signed [DEV_W-1:0] hot_v, cool_v, dv;

    always_comb begin
        hot_idx  = '0;
        hot_ok   = 1'b0;
        hot_v    = '0;
        cool_idx = '0;
        cool_ok  = 1'b0;
        cool_v   = '0;
        dv       = '0;
        for (int i = 0; i < N_CORES; i++) begin
            dv = $signed(dev_flat[i*DEV_W +: DEV_W]);
            if (occ[i]) begin
                if (!hot_ok || dv > hot_v) begin
                    hot_ok  = 1'b1;
                    hot_v   = dv;
                    hot_idx = IDX_W'(i);
                end
            end else begin
                if (!cool_ok || dv < cool_v) begin
                    cool_ok  = 1'b1;
                    cool_v   = dv;
                    cool_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/thermal_migr_coord.sv
module thermal_migr_coord
    import thermco_pkg::*;
#(
    parameter int N_CORES   = 8,
    parameter int TASK_W    = 4,
    parameter int PRED_W    = 8,
    parameter int DEV_W     = 8,
    parameter int PRO_LVL   = 39,
    parameter int AVAIL_LVL = 33,
    parameter int BAL_LVL   = 3,
    localparam int IDX_W    = $clog2(N_CORES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic [N_CORES-1:0]        core_busy,
    input  logic [N_CORES*TASK_W-1:0] core_task,
    input  logic [N_CORES*PRED_W-1:0] thr_pred,
    input  logic [N_CORES*DEV_W-1:0]  bal_dev,
    output logic                      cmd_valid,
    output logic                      cmd_start,
    output logic                      cmd_fmax,
    output logic [IDX_W-1:0]          cmd_core,
    output logic [TASK_W-1:0]         cmd_task
);
    localparam int CNT_W = $clog2(N_CORES + 1);
    localparam int DIVD  = BAL_LVL * N_CORES;
    localparam int Q_W   = (DIVD > 3) ? $clog2(DIVD + 1) : 2;
    localparam int CMP_W = ((DEV_W > Q_W) ? DEV_W : Q_W) + 1;
    localparam logic [PRED_W-1:0] PRO_V   = PRED_W'(PRO_LVL);
    localparam logic [PRED_W-1:0] AVAIL_V = PRED_W'(AVAIL_LVL);

    coord_state_e st;
    logic [IDX_W-1:0]          idx;
    logic [N_CORES*PRED_W-1:0] pat_q;
    logic [N_CORES*DEV_W-1:0]  dev_q;
    logic [N_CORES*TASK_W-1:0] task_q;
    logic [N_CORES-1:0]        occ;
    logic [CNT_W-1:0]          m_cnt, busy_ones;
    logic                      thr_hit, div_started, issue_ph;
    logic [IDX_W-1:0]          src_q, dst_q;
    cmd_op_t                   op_q;

    logic [PRED_W-1:0] cur_pat;
    logic [TASK_W-1:0] cur_task, head_task, src_task;
    logic              last_core, stop_now, assign_now, bal_go;
    logic              q_empty, q_full;
    logic              div_start, div_done;
    logic [Q_W-1:0]    dybal;
    logic [IDX_W-1:0]  hot_idx, cool_idx;
    logic              hot_ok, cool_ok;
    logic signed [CMP_W-1:0] hot_ext, trig_ext;

    always_comb begin
        busy_ones = '0;
        for (int i = 0; i < N_CORES; i++) begin
            busy_ones = busy_ones + CNT_W'(core_busy[i]);
        end
    end

    assign cur_pat    = pat_q[idx*PRED_W +: PRED_W];
    assign cur_task   = task_q[idx*TASK_W +: TASK_W];
    assign src_task   = task_q[src_q*TASK_W +: TASK_W];
    assign last_core  = (idx == IDX_W'(N_CORES - 1));
    assign stop_now   = (st == ST_THRESH_SCAN) && occ[idx] && (cur_pat >= PRO_V) && !q_full;
    assign assign_now = (st == ST_ASSIGN) && !q_empty && !occ[idx] && (cur_pat <= AVAIL_V);
    assign div_start  = (st == ST_BAL_WAIT) && !div_started && !thr_hit && q_empty
                        && (m_cnt != '0);
    assign hot_ext    = CMP_W'($signed(dev_q[hot_idx*DEV_W +: DEV_W]));
    assign trig_ext   = $signed({{(CMP_W-Q_W){1'b0}}, dybal});
    assign bal_go     = (st == ST_BAL_ACT) && hot_ok && cool_ok && (hot_ext >= trig_ext);

    assign cmd_start  = op_q.start;
    assign cmd_fmax   = op_q.fmax;

    thermco_taskq #(.DEPTH(N_CORES), .W(TASK_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (stop_now),
        .din   (cur_task),
        .pop   (assign_now),
        .dout  (head_task),
        .empty (q_empty),
        .full  (q_full)
    );

    thermco_div #(.DIVD_W(Q_W), .DIVS_W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (Q_W'(DIVD)),
        .divisor  (m_cnt),
        .done     (div_done),
        .quo      (dybal)
    );

    thermco_pick #(.N_CORES(N_CORES), .DEV_W(DEV_W), .IDX_W(IDX_W)) u_pick (
        .dev_flat (dev_q),
        .occ      (occ),
        .hot_idx  (hot_idx),
        .hot_ok   (hot_ok),
        .cool_idx (cool_idx),
        .cool_ok  (cool_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            idx         <= '0;
            pat_q       <= '0;
            dev_q       <= '0;
            task_q      <= '0;
            occ         <= '0;
            m_cnt       <= '0;
            thr_hit     <= 1'b0;
            div_started <= 1'b0;
            issue_ph    <= 1'b0;
            src_q       <= '0;
            dst_q       <= '0;
            cmd_valid   <= 1'b0;
            op_q        <= OP_STOP;
            cmd_core    <= '0;
            cmd_task    <= '0;
        end else begin
            cmd_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (tick) begin
                        pat_q       <= thr_pred;
                        dev_q       <= bal_dev;
                        task_q      <= core_task;
                        occ         <= core_busy;
                        m_cnt       <= busy_ones;
                        thr_hit     <= 1'b0;
                        div_started <= 1'b0;
                        issue_ph    <= 1'b0;
                        idx         <= '0;
                        st          <= ST_THRESH_SCAN;
                    end
                end
                ST_THRESH_SCAN: begin
                    if (stop_now) begin
                        cmd_valid <= 1'b1;
                        op_q      <= OP_STOP;
                        cmd_core  <= idx;
                        cmd_task  <= cur_task;
                        occ[idx]  <= 1'b0;
                        thr_hit   <= 1'b1;
                    end
                    if (last_core) begin
                        idx <= '0;
                        st  <= ST_ASSIGN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_ASSIGN: begin
                    if (assign_now) begin
                        cmd_valid <= 1'b1;
                        op_q      <= OP_START;
                        cmd_core  <= idx;
                        cmd_task  <= head_task;
                        occ[idx]  <= 1'b1;
                        thr_hit   <= 1'b1;
                    end
                    if (last_core || q_empty) begin
                        idx <= '0;
                        st  <= ST_BAL_WAIT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_BAL_WAIT: begin
                    if (!div_started) begin
                        if (div_start) begin
                            div_started <= 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else if (div_done) begin
                        st <= ST_BAL_ACT;
                    end
                end
                ST_BAL_ACT: begin
                    if (bal_go) begin
                        src_q    <= hot_idx;
                        dst_q    <= cool_idx;
                        issue_ph <= 1'b0;
                        st       <= ST_ISSUE;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_ISSUE: begin
                    cmd_valid <= 1'b1;
                    cmd_task  <= src_task;
                    if (!issue_ph) begin
                        op_q     <= OP_STOP;
                        cmd_core <= src_q;
                        issue_ph <= 1'b1;
                    end else begin
                        op_q     <= OP_START;
                        cmd_core <= dst_q;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5: the balance decision is only reached in a quiet interval
    assert_bal_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BAL_ACT) |-> (!thr_hit && q_empty));

    // R2: a stop from the scan targets a core at or above the proactive level
    assert_stop_hot_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_start && $past(st) == ST_THRESH_SCAN)
        |-> (pat_q[cmd_core*PRED_W +: PRED_W] >= PRO_V));

    // R6: the second half of a balance move is always a start
    assert_issue_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ISSUE && issue_ph) |=> (cmd_valid && cmd_start));

    // R9: frequency request follows the command direction
    assert_freq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_fmax == cmd_start));

endmodule

// File: tb/thermal_migr_coord_test.sv
module thermal_migr_coord_test;
    localparam int NC = 8;
    localparam int TW = 4;
    localparam int PW = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [NC-1:0]    core_busy = '0;
    logic [NC*TW-1:0] core_task = '0;
    logic [NC*PW-1:0] thr_pred = '0;
    logic [NC*DW-1:0] bal_dev = '0;
    logic cmd_valid, cmd_start, cmd_fmax;
    logic [2:0]    cmd_core;
    logic [TW-1:0] cmd_task;

    always #2.5 clk = ~clk;

    thermal_migr_coord uut (
        .clk(clk), .rst(rst), .tick(tick),
        .core_busy(core_busy), .core_task(core_task),
        .thr_pred(thr_pred), .bal_dev(bal_dev),
        .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_fmax(cmd_fmax),
        .cmd_core(cmd_core), .cmd_task(cmd_task)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int busy[NC];
    int tid[NC];
    int pat[NC];
    int dev[NC];
    int mq[$];
    int exp_start[$];
    int exp_core[$];
    int exp_task[$];
    string exp_tag[$];
    int lcg = 12345;

    function automatic int rnd(input int lo, input int hi);
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return lo + ((lcg >>> 8) % (hi - lo + 1));
    endfunction

    task automatic expect_cmd(input int st, input int c, input int t, input string tag);
        exp_start.push_back(st);
        exp_core.push_back(c);
        exp_task.push_back(t);
        exp_tag.push_back(tag);
    endtask

    // Behavioural reference: builds this interval's command list and updates the environment
    task automatic model_interval(input string tag);
        int occ[NC];
        int thr;
        int m;
        int hot;
        int cool;
        thr = 0;
        m = 0;
        for (int i = 0; i < NC; i++) begin
            occ[i] = busy[i];
            m += busy[i];
        end
        for (int i = 0; i < NC; i++) begin
            if (occ[i] == 1 && pat[i] >= 39 && mq.size() < NC) begin
                expect_cmd(0, i, tid[i], tag);
                mq.push_back(tid[i]);
                occ[i] = 0;
                thr = 1;
            end
        end
        for (int i = 0; i < NC; i++) begin
            if (mq.size() > 0 && occ[i] == 0 && pat[i] <= 33) begin
                tid[i] = mq.pop_front();
                expect_cmd(1, i, tid[i], tag);
                occ[i] = 1;
                thr = 1;
            end
        end
        if (thr == 0 && mq.size() == 0 && m != 0) begin
            hot = -1;
            cool = -1;
            for (int i = 0; i < NC; i++) begin
                if (occ[i] == 1 && (hot < 0 || dev[i] > dev[hot])) hot = i;
                if (occ[i] == 0 && (cool < 0 || dev[i] < dev[cool])) cool = i;
            end
            if (hot >= 0 && cool >= 0 && dev[hot] >= (3 * NC) / m) begin
                expect_cmd(0, hot, tid[hot], tag);
                expect_cmd(1, cool, tid[hot], tag);
                occ[hot] = 0;
                occ[cool] = 1;
                tid[cool] = tid[hot];
            end
        end
        for (int i = 0; i < NC; i++) busy[i] = occ[i];
    endtask

    task automatic run_interval(input string tag);
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            core_busy[i] = busy[i][0];
            core_task[i*TW +: TW] = TW'(tid[i]);
            thr_pred[i*PW +: PW] = PW'(pat[i]);
            bal_dev[i*DW +: DW] = DW'(dev[i]);
        end
        model_interval(tag);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (60) @(negedge clk);
        checks++;
        if (exp_start.size() != 0) begin
            failures++;
            $display("FAIL %s: missing commands actual=0 expected=%0d", tag, exp_start.size());
            exp_start.delete(); exp_core.delete(); exp_task.delete(); exp_tag.delete();
        end
    endtask

    // Compare every clock against the expected command list
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            checks++;
            if (exp_start.size() == 0) begin
                failures++;
                $display("FAIL unexpected command actual=start%0d/core%0d/task%0d expected=none",
                         cmd_start, cmd_core, cmd_task);
            end else begin
                if (int'(cmd_start) != exp_start[0] || int'(cmd_core) != exp_core[0] ||
                    int'(cmd_task) != exp_task[0] || cmd_fmax != cmd_start) begin
                    failures++;
                    $display("FAIL %s (R9 encoding) actual=start%0d/fmax%0d/core%0d/task%0d expected=start%0d/fmax%0d/core%0d/task%0d",
                             exp_tag[0], cmd_start, cmd_fmax, cmd_core, cmd_task,
                             exp_start[0], exp_start[0], exp_core[0], exp_task[0]);
                end
                void'(exp_start.pop_front());
                void'(exp_core.pop_front());
                void'(exp_task.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    task automatic set_all(input int p, input int d);
        for (int i = 0; i < NC; i++) begin
            pat[i] = p;
            dev[i] = d;
        end
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin
            busy[i] = 0; tid[i] = 0;
        end
        set_all(20, 0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset
        repeat (5) @(negedge clk);
        checks++;
        if (cmd_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%0b expected=0", cmd_valid);
        end
        // R1 / R7: idle chip with M=0 issues nothing
        dev[0] = 50;
        run_interval("R1");
        // R7: below trigger (M=4 -> 6)
        for (int i = 0; i < 4; i++) begin busy[i] = 1; tid[i] = i + 1; end
        set_all(30, 1);
        dev[0] = 5; dev[4] = -2; dev[5] = -4; dev[6] = -4; dev[7] = 0;
        run_interval("R7");
        // R6: at trigger, move to lowest-deviation free core, tie lowest index
        dev[0] = 6;
        run_interval("R6");
        // R2/R3/R5: stop at 39, keep at 38, assign at 33 only, no balance
        set_all(30, 0);
        for (int i = 0; i < NC; i++) if (busy[i] == 1) pat[i] = 38;
        pat[1] = 39; pat[2] = 45;
        for (int i = 0; i < NC; i++) if (busy[i] == 0) pat[i] = 34;
        pat[6] = 33; dev[3] = 40;
        run_interval("R2");
        // R4/R5: queued task waits, no balance despite big deviation
        set_all(36, 0); dev[3] = 40;
        run_interval("R4");
        // R4: cool free core takes the waiting task
        set_all(20, 0);
        run_interval("R4");
        // R6 at a different occupancy
        set_all(20, 0);
        for (int i = 0; i < NC; i++) if (busy[i] == 1) begin dev[i] = 8; break; end
        run_interval("R6");
        // R8: fill the queue completely
        for (int i = 0; i < NC; i++) if (busy[i] == 0) begin busy[i] = 1; tid[i] = 8 + i; end
        set_all(45, 0);
        run_interval("R2");
        // R8: new hot tasks must stay while the queue is full
        for (int i = 0; i < 3; i++) begin busy[i] = 1; tid[i] = 13 + i; end
        set_all(50, 0);
        run_interval("R8");
        checks++;
        if (core_busy[2:0] != 3'b111 || mq.size() != NC) begin
            failures++;
            $display("FAIL R8 occupancy actual=%0d expected=%0d", mq.size(), NC);
        end
        // R3: cool down, queue drains oldest first into free cores
        set_all(10, 0);
        run_interval("R3");
        run_interval("R3");
        // mixed intervals
        for (int k = 0; k < 30; k++) begin
            for (int i = 0; i < NC; i++) begin
                pat[i] = rnd(25, 45);
                dev[i] = rnd(-10, 12);
            end
            run_interval("R6");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule